// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It supports six operations: register add and subtract without overflow traps, OR with a zero-extended immediate, word load, word store, and branch on equal. The core holds the program counter and next-address logic, a decoder, a 32-entry register file, an immediate extender, an ALU, and small instruction and data memories. Every piece of state takes its new value on the same rising edge.

The memories are filled through a load port while the core is held in reset. After reset is released, the core fetches from address 0. The program counter and the register write of the current instruction appear on output ports, so the surrounding logic can watch execution as it happens.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and all registers become 0. `rf_we_o` stays low for every cycle in which `rst_n` is low.
- R2: Opcode 0x00 with funct 0x21 writes rs+rt to rd, and funct 0x23 writes rs−rt to rd, both modulo 2^32. Fields: op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0].
- R3: Opcode 0x0D writes rs OR {16'h0, imm16[15:0]} to rt.
- R4: Opcode 0x23 writes to rt the data word at byte address rs + sign-extended imm16. The word index is taken from address bits [DAW+1:2], so higher address bits wrap.
- R5: Opcode 0x2B stores rt to the data word at that same address and writes no register.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm16 << 2) when rs equals rt, and to PC+4 otherwise. It writes no register.
- R7: Register 0 always reads 0. A write aimed at it is dropped, and `rf_we_o` stays low for it.
- R8: Any other opcode, and opcode 0x00 with any other funct, writes nothing and advances the PC by 4.
- R9: `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` show, during the cycle, the write that commits at the closing edge. The next instruction reads the new value.
- R10: The instruction is fetched from word PC[IAW+1:2]. When the instruction is not a taken branch, the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_imem_we | input | 1 | Write `ld_data` into instruction memory |
| ld_dmem_we | input | 1 | Write `ld_data` into data memory |
| ld_addr | input | 32 | Byte address for the load port |
| ld_data | input | 32 | Word written through the load port |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | A register write commits at the coming edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |

## Verification
The bench builds the core with 64 instruction words and only 16 data words. With the small data memory, a load offset of 0x48 aliases word 2, and a negative offset from register 0 reaches the top word. This brings the address wrap of R4 and the sign extension into reach with short programs. The program loops back to address 0 through a backward branch. A second reset with a different first instruction shows that the registers were cleared. Each cycle is compared against a behavioural model of the instruction set.

// File: rtl/sc_pkg.sv
// Package: shared opcode values, ALU operation codes and the decoded
// control bundle used by the single-cycle core.
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;   // destination taken from rd instead of rt
        logic    use_imm;     // second ALU operand is the extended immediate
        logic    imm_signed;  // sign-extend (1) or zero-extend (0)
        alu_op_e alu_op;
        logic    mem_write;
        logic    wb_from_mem; // write back load data instead of ALU result
        logic    reg_write;
        logic    is_branch;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Module: sc_decode
// Turns opcode and funct into the control bundle. It is pure combinational
// logic. Any encoding outside the supported six produces an all-inactive
// bundle, so the instruction falls through to PC+4 with no writes.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Purpose: map each supported encoding onto its control settings.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (op)
            OP_RTYPE: begin
                if (funct == FN_ADDU || funct == FN_SUBU) begin
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.reg_write = 1'b1;
                    ctrl.alu_op    = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
                end
            end
            OP_ORI: begin
                ctrl.use_imm   = 1'b1;
                ctrl.alu_op    = ALU_OR;
                ctrl.reg_write = 1'b1;
            end
            OP_LOAD: begin
                ctrl.use_imm     = 1'b1;
                ctrl.imm_signed  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
            end
            OP_STORE: begin
                ctrl.use_imm    = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.mem_write  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.imm_signed = 1'b1;
                ctrl.is_branch  = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_fetch.sv
// Module: sc_fetch
// Holds the PC and the instruction memory and computes the next address.
// Assumes the memory is filled through the load port during reset. Reads
// are combinational on the PC word index.
module sc_fetch #(
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_we,
    input  logic [AW-1:0] ld_idx,
    input  logic [31:0] ld_data,
    input  logic        take_branch,
    input  logic [31:0] offset_ext,
    output logic [31:0] pc,
    output logic [31:0] instr
);

    logic [31:0] mem [WORDS];
    logic [31:0] pc_seq;
    logic [31:0] pc_next;

    // Purpose: sequential and branch-target address selection.
    always_comb begin
        pc_seq  = pc + 32'd4;
        pc_next = take_branch ? (pc_seq + {offset_ext[29:0], 2'b00}) : pc_seq;
    end

    // Purpose: PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    // Purpose: instruction memory fill from the load port.
    always_ff @(posedge clk) begin
        if (ld_we) mem[ld_idx] <= ld_data;
    end

    assign instr = mem[pc[AW+1:2]];

endmodule

// File: rtl/sc_regfile.sv
// Module: sc_regfile
// 32-entry register file with two combinational read ports and one write
// port that commits on the clock edge. Entry 0 is a constant zero, so writes
// to it vanish. All other entries clear on synchronous reset.
module sc_regfile #(
    parameter int DW    = 32,
    parameter int NREG  = 32,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] q_vec [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign q_vec[i] = '0;
        end else begin : g_store
            logic [DW-1:0] q;
            // Purpose: one register entry; clears on reset, loads on a match.
            always_ff @(posedge clk) begin
                if (!rst_n)                           q <= '0;
                else if (we && waddr == IW'(i))       q <= wdata;
            end
            assign q_vec[i] = q;
        end
    end

    assign rdata_a = q_vec[raddr_a];
    assign rdata_b = q_vec[raddr_b];

endmodule

// File: rtl/sc_exec.sv
// Module: sc_exec
// Immediate extender, operand select, ALU and equality compare. All of it is
// combinational. The compare works on the raw register operands and never
// on the immediate.
module sc_exec
    import sc_pkg::*;
(
    input  ctrl_t       ctrl,
    input  logic [31:0] bus_a,
    input  logic [31:0] bus_b,
    input  logic [15:0] imm16,
    output logic [31:0] imm_ext,
    output logic [31:0] result,
    output logic        equal
);

    logic [31:0] opnd_b;

    // Purpose: zero or sign extension picked by the decoder.
    always_comb begin
        imm_ext = ctrl.imm_signed ? {{16{imm16[15]}}, imm16} : {16'h0000, imm16};
        opnd_b  = ctrl.use_imm ? imm_ext : bus_b;
    end

    // Purpose: ALU operation select.
    always_comb begin
        unique case (ctrl.alu_op)
            ALU_SUB: result = bus_a - opnd_b;
            ALU_OR:  result = bus_a | opnd_b;
            default: result = bus_a + opnd_b;
        endcase
    end

    assign equal = (bus_a == bus_b);

endmodule

// File: rtl/sc_dmem.sv
// Module: sc_dmem
// Word-addressed data memory. Reads are combinational. Writes happen on the
// edge. The load port wins over a core store in the same cycle, though the
// two are meant never to overlap.
module sc_dmem #(
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          core_we,
    input  logic [AW-1:0] core_idx,
    input  logic [31:0]   core_wdata,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_idx,
    input  logic [31:0]   ld_data,
    output logic [31:0]   rdata
);

    logic [31:0] mem [WORDS];

    // Purpose: single write port shared by the fill path and stores.
    always_ff @(posedge clk) begin
        if (ld_we)        mem[ld_idx]   <= ld_data;
        else if (core_we) mem[core_idx] <= core_wdata;
    end

    assign rdata = mem[core_idx];

endmodule

// File: rtl/sc_core.sv
// Module: sc_core
// Top of the single-cycle core. Fetch, decode, register read, execute,
// memory access and write-back all happen in one cycle. Every state update
// commits on one rising edge. Writes are gated by reset, and register 0
// never reports a write.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW       = $clog2(IMEM_WORDS),
    localparam int DAW       = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_imem_we,
    input  logic            ld_dmem_we,
    input  logic [31:0]     ld_addr,
    input  logic [31:0]     ld_data,
    output logic [31:0]     pc_o,
    output logic            rf_we_o,
    output logic [RIDX-1:0] rf_waddr_o,
    output logic [31:0]     rf_wdata_o
);

    logic [31:0]     instr;
    ctrl_t           ctrl;
    logic [31:0]     bus_a, bus_b;
    logic [31:0]     imm_ext, alu_res, dmem_rdata;
    logic            equal;
    logic            dmem_we;
    logic [RIDX-1:0] waddr;
    logic [31:0]     wdata;
    logic            reg_we;
    logic            unused_bits;

    assign unused_bits = ^{instr[10:6], ld_addr[31:2+IAW], ld_addr[1:0],
                           alu_res[31:2+DAW], alu_res[1:0]};

    sc_fetch #(.WORDS(IMEM_WORDS)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_we       (ld_imem_we),
        .ld_idx      (ld_addr[IAW+1:2]),
        .ld_data     (ld_data),
        .take_branch (ctrl.is_branch & equal),
        .offset_ext  (imm_ext),
        .pc          (pc_o),
        .instr       (instr)
    );

    sc_decode u_decode (
        .op    (instr[31:26]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    sc_regfile #(.DW(XLEN), .NREG(32)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (bus_a),
        .rdata_b (bus_b)
    );

    sc_exec u_exec (
        .ctrl    (ctrl),
        .bus_a   (bus_a),
        .bus_b   (bus_b),
        .imm16   (instr[15:0]),
        .imm_ext (imm_ext),
        .result  (alu_res),
        .equal   (equal)
    );

    sc_dmem #(.WORDS(DMEM_WORDS)) u_dmem (
        .clk        (clk),
        .core_we    (dmem_we),
        .core_idx   (alu_res[DAW+1:2]),
        .core_wdata (bus_b),
        .ld_we      (ld_dmem_we),
        .ld_idx     (ld_addr[DAW+1:2]),
        .ld_data    (ld_data),
        .rdata      (dmem_rdata)
    );

    // Purpose: write-back selection and reset/zero-register gating.
    always_comb begin
        waddr   = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
        wdata   = ctrl.wb_from_mem ? dmem_rdata : alu_res;
        reg_we  = rst_n && ctrl.reg_write && (waddr != '0);
        dmem_we = rst_n && ctrl.mem_write;
    end

    assign rf_we_o    = reg_we;
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wdata;

endmodule

// File: rtl/sc_core_chk.sv
// Module: sc_core_chk
// Property checker bound into sc_core. It watches the PC sequence, the
// branch outcome and the write strobes.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] bus_a,
    input logic [31:0] bus_b,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic        mem_we
);

    AST_RESET_PC: assert property (@(posedge clk)
        !rst_n |=> (pc == 32'd0)); // R1

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] != 6'h04) |=> (pc == $past(pc) + 32'd4)); // R10

    AST_BEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'h04 && bus_a != bus_b) |=> (pc == $past(pc) + 32'd4)); // R6

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'h04 && bus_a == bus_b)
        |=> (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00})); // R6

    AST_ZERO_REG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != 5'd0)); // R7

    AST_WRITE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (instr[31:26] == 6'h00 || instr[31:26] == 6'h0D || instr[31:26] == 6'h23)); // R8

    AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!rf_we && !mem_we)); // R1

endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_o),
    .instr    (instr),
    .bus_a    (bus_a),
    .bus_b    (bus_b),
    .rf_we    (rf_we_o),
    .rf_waddr (rf_waddr_o),
    .mem_we   (dmem_we)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
// Bench: behavioural instruction-set model, compared every cycle.
module sc_core_tb;

    localparam int IW = 64;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
    logic [31:0] ld_addr = '0, ld_data = '0;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
    );

    // Model state
    logic [31:0] m_pc;
    logic [31:0] m_rf [32];
    logic [31:0] m_im [IW];
    logic [31:0] m_dm [DW];
    bit          m_valid = 1'b0;
    string       last_tag = "R1";

    function automatic logic [31:0] rt_ins(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] it_ins(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Predicted write activity and tag of one instruction on model state.
    task automatic predict(input logic [31:0] ins, output bit we, output logic [4:0] wa,
                           output logic [31:0] wd, output string tag);
        logic [31:0] a, b, sx, adr;
        a  = m_rf[ins[25:21]];
        b  = m_rf[ins[20:16]];
        sx = {{16{ins[15]}}, ins[15:0]};
        adr = a + sx;
        we = 0; wa = '0; wd = '0; tag = "R8";
        case (ins[31:26])
            6'h00: if (ins[5:0] == 6'h21 || ins[5:0] == 6'h23) begin
                       wa = ins[15:11];
                       wd = (ins[5:0] == 6'h21) ? a + b : a - b;
                       we = 1; tag = "R2";
                   end
            6'h0D: begin wa = ins[20:16]; wd = a | {16'h0, ins[15:0]}; we = 1; tag = "R3"; end
            6'h23: begin wa = ins[20:16]; wd = m_dm[adr[5:2]]; we = 1; tag = "R4"; end
            6'h2B: tag = "R5";
            6'h04: tag = "R6";
            default: tag = "R8";
        endcase
        if (we && wa == 5'd0) begin we = 0; tag = "R7"; end
    endtask

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Advance the model across one rising edge.
    task automatic model_edge();
        bit we; logic [4:0] wa; logic [31:0] wd; string tag;
        logic [31:0] ins, a, b, sx, adr;
        if (ld_imem_we) m_im[ld_addr[7:2]] = ld_data;
        if (ld_dmem_we) m_dm[ld_addr[5:2]] = ld_data;
        if (!rst_n) begin
            m_pc = '0; m_valid = 1;
            for (int i = 0; i < 32; i++) m_rf[i] = '0;
            last_tag = "R1";
        end else if (m_valid) begin
            ins = m_im[m_pc[7:2]];
            predict(ins, we, wa, wd, tag);
            a  = m_rf[ins[25:21]];
            b  = m_rf[ins[20:16]];
            sx = {{16{ins[15]}}, ins[15:0]};
            adr = a + sx;
            if (ins[31:26] == 6'h2B) m_dm[adr[5:2]] = b;
            if (we) m_rf[wa] = wd;
            if (ins[31:26] == 6'h04 && a == b) begin
                m_pc = m_pc + 32'd4 + {sx[29:0], 2'b00}; last_tag = "R6";
            end else begin
                m_pc = m_pc + 32'd4; last_tag = (ins[31:26] == 6'h04) ? "R6" : "R10";
            end
        end
    endtask

    // Compare outputs mid-cycle against the model.
    task automatic compare();
        bit we; logic [4:0] wa; logic [31:0] wd; string tag;
        if (!rst_n) begin
            chk(rf_we_o == 1'b0, "R1", "write strobe in reset", 32'(rf_we_o), 32'd0);
        end else if (m_valid) begin
            predict(m_im[m_pc[7:2]], we, wa, wd, tag);
            chk(pc_o === m_pc, last_tag, "pc", pc_o, m_pc);
            chk(rf_we_o === we, tag, "write strobe", 32'(rf_we_o), 32'(we));
            if (we) begin
                chk(rf_waddr_o === wa, "R9", "write address", 32'(rf_waddr_o), 32'(wa));
                chk(rf_wdata_o === wd, tag, "write data", rf_wdata_o, wd);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic load_word(bit to_imem, int idx, logic [31:0] val);
        ld_imem_we = to_imem;
        ld_dmem_we = !to_imem;
        ld_addr    = 32'(idx) << 2;
        ld_data    = val;
        tick();
        ld_imem_we = 0;
        ld_dmem_we = 0;
    endtask

    logic [31:0] prog [16];

    initial begin
        prog[0]  = it_ins(6'h0D, 0, 1, 16'h8001);      // ori  r1 = 0x8001
        prog[1]  = it_ins(6'h0D, 1, 2, 16'h00F0);      // ori  r2 reads new r1
        prog[2]  = rt_ins(1, 2, 3, 6'h21);             // addu r3
        prog[3]  = rt_ins(0, 1, 4, 6'h23);             // subu r4 = 0 - r1 (wrap)
        prog[4]  = it_ins(6'h2B, 0, 4, 16'h0008);      // sw   r4 -> word 2
        prog[5]  = it_ins(6'h23, 0, 5, 16'h0008);      // lw   r5 <- word 2
        prog[6]  = it_ins(6'h23, 0, 6, 16'h0048);      // lw   r6, aliases word 2
        prog[7]  = it_ins(6'h23, 8, 7, 16'hFFFC);      // lw   r7, negative offset
        prog[8]  = it_ins(6'h0D, 0, 0, 16'h1234);      // ori  r0 dropped
        prog[9]  = rt_ins(0, 0, 9, 6'h21);             // addu r9 = r0 + r0
        prog[10] = it_ins(6'h04, 5, 6, 16'h0001);      // beq  taken
        prog[11] = it_ins(6'h0D, 0, 10, 16'h0BAD);     // skipped
        prog[12] = it_ins(6'h04, 1, 2, 16'h0005);      // beq  not taken
        prog[13] = 32'hFC00_0000;                      // unknown opcode
        prog[14] = rt_ins(1, 2, 11, 6'h20);            // op 0, unsupported funct
        prog[15] = it_ins(6'h04, 0, 0, 16'hFFF0);      // beq  back to 0

        rst_n = 0;
        @(negedge clk);
        for (int i = 0; i < IW; i++) load_word(1, i, (i < 16) ? prog[i] : 32'h0);
        for (int i = 0; i < DW; i++) load_word(0, i, 32'hCAFE_0000 + 32'(i));
        tick();
        rst_n = 1;
        for (int i = 0; i < 60; i++) tick();

        // Second reset: new first instruction reads r3, which must be cleared (R1)
        rst_n = 0;
        load_word(1, 0, rt_ins(3, 0, 12, 6'h21));
        tick();
        rst_n = 1;
        for (int i = 0; i < 40; i++) tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule